// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a word of digital inputs and raises an interrupt when some of the lower sixteen inputs meet a condition that software sets up. All inputs can be read back through a small 32-bit register bus. Software picks a set of channels through two masks. One mask holds the rising-edge or high-level channels. The other holds the falling-edge or low-level channels. Software also picks one of two combining modes.

In the edge mode, any selected edge raises the interrupt. In the level mode, the interrupt is raised when every selected channel sits at its required level. After that the level logic stays locked until one of the selected channels changes level. The interrupt output stays high until software reads the status word, which clears it, or until software clears the enable bit. The status word records which channels caused the event.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, control, both masks and status read as zero, and `irq_out` is low.
- R2: Word address 0x00 returns the inputs after a two-flop synchroniser, on all 32 bits. An unmapped read, such as 0x14, returns zero.
- R3: The high mask at 0x04 and the low mask at 0x08 read back all 32 written bits. Control at 0x10 reads back bit 2 (enable) and bit 1 (mode: 0 edge, 1 level), and zeros elsewhere.
- R4: In edge mode with enable set, a rising edge on a channel set in the high mask, or a falling edge on a channel set in the low mask, raises `irq_out`. An edge on a channel not selected has no effect.
- R5: In edge mode, a channel set in both masks reacts to both edges.
- R6: Inputs 16 to 31 never raise the interrupt and never set a status bit, whatever the masks hold.
- R7: In level mode, the interrupt is raised when every high-mask channel is 1 and every low-mask channel is 0, with at least one channel selected.
- R8: After a level-mode interrupt, no new interrupt is raised while the condition stays met. A level change on a selected channel re-arms the logic, and a change on a channel not selected does not.
- R9: Reading status at 0x0C returns the captured channel bits in bits 15:0 and clears them. In edge mode these are the channels whose edges fired. In level mode they are the selected channels. Bits 31:16 always read zero.
- R10: `irq_out` stays high from the event until the status read, and falls in the cycle after that read.
- R11: Writing control with bit 2 at zero drops `irq_out`. Setting bit 2 again resumes with the masks that are still held.
- R12: Writes to the input word (0x00) and the status word (0x0C) have no effect.
- R13: With both masks zero, no input activity raises the interrupt in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; a status read clears at the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pins_in | input | 32 | Asynchronous digital inputs |
| irq_out | output | 1 | Interrupt level |

## Verification
The assertions assume that each bus strobe lasts one cycle and that reads and writes never occur in the same cycle. They also assume that the inputs only matter through the synchroniser, so a pin change shows up two edges later. The bench drives the strobes at the falling edge, one access at a time. It gives every pin change at least five cycles before it samples, so each change of pins is seen as exactly one event. Random trials change many bits at once under random masks, and each trial runs in a single mode.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int N_IN  = 32,
  parameter int N_IRQ = 16,
  parameter int AW    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [N_IN-1:0] pins_in,
  output logic            irq_out
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] W_RAW  = IW'(0);
  localparam logic [IW-1:0] W_HI   = IW'(1);
  localparam logic [IW-1:0] W_LO   = IW'(2);
  localparam logic [IW-1:0] W_STAT = IW'(3);
  localparam logic [IW-1:0] W_CTRL = IW'(4);
  localparam int EN_BIT   = 2;
  localparam int MODE_BIT = 1;

  logic [N_IN-1:0]  sync1, sync2, prev;
  logic [31:0]      mask_hi, mask_lo;
  logic             en_q, and_q, lock_q, irq_q;
  logic [N_IRQ-1:0] stat_q;

  logic [IW-1:0] widx;
  assign widx = bus_addr[AW-1:2];

  logic wr_hi, wr_lo, wr_ctrl, rd_stat, dis_wr;
  assign wr_hi   = bus_wr && (widx == W_HI);
  assign wr_lo   = bus_wr && (widx == W_LO);
  assign wr_ctrl = bus_wr && (widx == W_CTRL);
  assign rd_stat = bus_rd && (widx == W_STAT);
  assign dis_wr  = wr_ctrl && !bus_wdata[EN_BIT];

  logic [N_IRQ-1:0] lvl, old, hi, lo, sel, edge_ev;
  assign lvl = sync2[N_IRQ-1:0];
  assign old = prev[N_IRQ-1:0];
  assign hi  = mask_hi[N_IRQ-1:0];
  assign lo  = mask_lo[N_IRQ-1:0];
  assign sel = hi | lo;
  assign edge_ev = (lvl & ~old & hi) | (~lvl & old & lo);

  logic and_met, sel_moved, fire_or, fire_and, fire;
  logic [N_IRQ-1:0] cap;
  assign and_met   = ((lvl & hi) == hi) && ((~lvl & lo) == lo) && (|sel);
  assign sel_moved = |((lvl ^ old) & sel);
  assign fire_or   = en_q && !and_q && (|edge_ev);
  assign fire_and  = en_q && and_q && and_met && !lock_q;
  assign fire      = (fire_or || fire_and) && !dis_wr;
  assign cap       = and_q ? sel : edge_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pins_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi <= '0;
      mask_lo <= '0;
      en_q    <= 1'b0;
      and_q   <= 1'b0;
    end else begin
      if (wr_hi) mask_hi <= bus_wdata;
      if (wr_lo) mask_lo <= bus_wdata;
      if (wr_ctrl) begin
        en_q  <= bus_wdata[EN_BIT];
        and_q <= bus_wdata[MODE_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (!(en_q && and_q)) begin
      lock_q <= 1'b0;
    end else if (fire && and_q) begin
      lock_q <= 1'b1;
    end else if (sel_moved) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (rd_stat ? '0 : stat_q) | (fire ? cap : '0);
      if (dis_wr)       irq_q <= 1'b0;
      else if (fire)    irq_q <= 1'b1;
      else if (rd_stat) irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      W_RAW:   bus_rdata[N_IN-1:0] = sync2;
      W_HI:    bus_rdata = mask_hi;
      W_LO:    bus_rdata = mask_lo;
      W_STAT:  bus_rdata[N_IRQ-1:0] = stat_q;
      W_CTRL:  begin
        bus_rdata[EN_BIT]   = en_q;
        bus_rdata[MODE_BIT] = and_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_out = irq_q;

  p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> en_q);

  p_fire_sets_irq_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq_q);

  p_status_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !fire) |=> (stat_q == '0));

  p_lock_after_fire_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && and_q) |=> lock_q);

  p_fire_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
    fire |-> (cap != '0));

  p_rise_needs_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(en_q));
endmodule

// File: tb/cos_irq_ctrl_bench.sv
module cos_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata, pins_in;
  logic        irq_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins_in), .irq_out(irq_out));

  function automatic logic [31:0] exp_edges(logic [31:0] o, logic [31:0] n,
                                            logic [31:0] h, logic [31:0] l);
    return ((n & ~o & h) | (~n & o & l)) & 32'h0000_FFFF;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [31:0] v);
    @(negedge clk);
    pins_in = v;
    settle(5);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, h, l, o, n, e;
    void'($urandom(32'd20240611));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; pins_in = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    rd(5'h10, d); check("R1 ctrl", d, 0);
    rd(5'h04, d); check("R1 hi", d, 0);
    rd(5'h08, d); check("R1 lo", d, 0);
    rd(5'h0C, d); check("R1 status", d, 0);
    check("R1 irq", irq_out, 0);

    set_pins(32'hA5C3_0F17);
    rd(5'h00, d); check("R2 raw", d, 32'hA5C3_0F17);
    rd(5'h14, d); check("R2 unmapped", d, 0);

    wr(5'h00, 32'h1234_5678);
    rd(5'h00, d); check("R12 raw write ignored", d, 32'hA5C3_0F17);
    wr(5'h04, 32'hDEAD_BEEF); wr(5'h08, 32'h0BAD_F00D);
    rd(5'h04, d); check("R3 hi", d, 32'hDEAD_BEEF);
    rd(5'h08, d); check("R3 lo", d, 32'h0BAD_F00D);
    wr(5'h10, 32'hFFFF_FFF9);
    rd(5'h10, d); check("R3 ctrl", d, 32'h0000_0000);
    wr(5'h10, 32'h0000_0006);
    rd(5'h10, d); check("R3 ctrl", d, 32'h0000_0006);

    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    set_pins(0);
    wr(5'h10, 32'h4);
    set_pins(32'hFFFF_FFFF); set_pins(0);
    check("R13 edge zero masks", irq_out, 0);
    wr(5'h10, 32'h6);
    set_pins(32'h0000_00FF);
    check("R13 level zero masks", irq_out, 0);
    wr(5'h10, 0); set_pins(0);

    wr(5'h10, 32'h4);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, d); check("R12 status write ignored", d, 0);
    o = 0;
    for (int i = 0; i < 40; i++) begin
      h = $urandom; l = $urandom; n = $urandom;
      wr(5'h04, h); wr(5'h08, l);
      set_pins(n);
      e = exp_edges(o, n, h, l);
      check("R4 irq", {31'b0, irq_out}, {31'b0, e != 0});
      rd(5'h0C, d); check("R9 status", d, e);
      check("R10 irq after read", irq_out, 0);
      o = n;
    end

    wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF);
    set_pins(o ^ 32'hFFFF_0000);
    check("R6 upper irq", irq_out, 0);
    rd(5'h0C, d); check("R6 upper status", d, 0);
    o = o ^ 32'hFFFF_0000;

    set_pins(0); rd(5'h0C, d);
    wr(5'h04, 32'h0000_0008); wr(5'h08, 32'h0000_0008);
    set_pins(32'h8);
    check("R5 rise", irq_out, 1);
    rd(5'h0C, d); check("R5 rise status", d, 32'h8);
    set_pins(0);
    check("R5 fall", irq_out, 1);
    settle(3);
    check("R10 held", irq_out, 1);
    wr(5'h10, 0);
    settle(1);
    check("R11 disable drops", irq_out, 0);
    rd(5'h04, d); check("R11 mask kept", d, 32'h8);
    rd(5'h0C, d);
    wr(5'h10, 32'h4);
    set_pins(32'h8);
    check("R11 resumes", irq_out, 1);
    rd(5'h0C, d);

    wr(5'h10, 0); set_pins(0);
    wr(5'h04, 32'h0000_0001); wr(5'h08, 32'h0000_0002);
    wr(5'h10, 32'h6);
    set_pins(32'h0000_0003);
    check("R7 not met", irq_out, 0);
    set_pins(32'h0000_0001);
    check("R7 met", irq_out, 1);
    rd(5'h0C, d); check("R9 level status", d, 32'h3);
    settle(4);
    check("R8 locked", irq_out, 0);
    set_pins(32'h0000_0021);
    check("R8 unselected no rearm", irq_out, 0);
    set_pins(32'h0000_0020);
    check("R8 condition lost", irq_out, 0);
    set_pins(32'h0000_0021);
    check("R8 rearmed fires", irq_out, 1);
    rd(5'h0C, d);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule